// File: doc/BRIEF.md
# DRAM Refresh Command Scheduler

This block sits inside a memory controller and keeps one DRAM rank refreshed. A free-running interval timer counts clock cycles and produces one refresh credit per refresh interval. When the high-temperature input is set, the interval is half the normal length. Credits are kept in a small pending counter. The scheduler issues one refresh command for each credit once the rank reports idle. The command carries no row address, because the device steps its own row counter.

In whole-rank mode, each command occupies every bank for the all-bank busy time, and the grant to new rank accesses is withdrawn for that time. In per-bank mode, each command targets one bank, chosen round-robin. Only that bank is marked busy, for the shorter per-bank busy time. The other banks stay available, so consecutive banks can be refreshed on consecutive cycles. Up to eight refreshes can be postponed while the rank is busy. When the backlog reaches that limit, grant is withdrawn until the owed refreshes are issued.

With the default parameters (20 ns clock), the normal interval is 390 cycles, the hot interval is 195 cycles, the all-bank busy time is 18 cycles and the per-bank busy time is 5 cycles.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `ref_cmd_o` and every `bank_busy_o` bit are 0, `grant_o` is 1, and the pending count is 0. The interval timer starts at the normal length, so with an idle rank the first command appears 391 cycles after reset release.
- R2: With `hot_i` low and the rank idle, a refresh credit is produced every 390 cycles. Each credit is followed, one cycle later, by a one-cycle pulse on `ref_cmd_o`.
- R3: The timer reloads with 195 cycles when `hot_i` is 1 at a reload, and with 390 cycles when it is 0 at a reload. A change of `hot_i` in the middle of an interval does not alter the interval that is already running.
- R4: A command is issued only when `rank_idle_i` was 1 on the previous cycle. While it is 0, credits accumulate instead.
- R5: A whole-rank command (`per_bank_i` = 0) drives `ref_all_o` = 1 and `ref_bank_o` = 0. It holds all `bank_busy_o` bits at 1 and `grant_o` at 0 for 18 cycles. After that, both are released if no backlog is full.
- R6: A whole-rank command waits until no bank is busy. A backlog therefore drains at one command every 19 cycles.
- R7: The pending count saturates at 8. Credits beyond that are dropped. While the count equals 8, `grant_o` is 0.
- R8: The interval timer runs freely. Delaying an issue does not shift the times at which later credits are produced.
- R9: A per-bank command (`per_bank_i` = 1) drives `ref_all_o` = 0. `ref_bank_o` steps through 0,1,...,7 and wraps to 0. Only the addressed bank's `bank_busy_o` bit (bit n for bank n) is 1, for 5 cycles, and `grant_o` stays 1.
- R10: In per-bank mode, a backlog is drained on consecutive cycles to consecutive banks, because a busy bank does not block a command to another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | Extended-temperature flag; selects the halved interval at the next reload |
| per_bank_i | input | 1 | 1 = refresh one bank per command, 0 = refresh the whole rank |
| rank_idle_i | input | 1 | Rank has no access in flight |
| grant_o | output | 1 | New rank accesses may be started |
| ref_cmd_o | output | 1 | One-cycle refresh command pulse |
| ref_all_o | output | 1 | Current command covers all banks |
| ref_bank_o | output | 3 | Bank targeted by a per-bank command; 0 for whole-rank |
| bank_busy_o | output | 8 | Per-bank refresh busy flags |

## Verification
The bench exercises the scheduler with five patterns:

- An always-idle rank in whole-rank mode, which pins down the interval length and the busy window.
- A mid-interval temperature switch in both directions, which separates an immediate interval change from one that waits for the next reload.
- A rank held busy across nine intervals and then released. This separates a saturating backlog from an unbounded one, and a free-running timer from one restarted on issue.
- An idle rank in per-bank mode.
- A per-bank backlog drain, which shows round-robin order with wrap and that only one bank is blocked at a time.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic {
        MODE_RANK = 1'b0,
        MODE_BANK = 1'b1
    } ref_mode_e;

    function automatic int ns_to_cycles_ceil(input int ns, input int clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int ns_to_cycles_floor(input int ns, input int clk_ps);
        return (ns * 1000) / clk_ps;
    endfunction

endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
    parameter int NORM_CYC = 390,
    parameter int HOT_CYC  = 195
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hot_i,
    output logic tick_o
);
    localparam int CW = (NORM_CYC > 1) ? $clog2(NORM_CYC) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == '0);

    always_comb begin
        if (tick_o) begin
            cnt_d = hot_i ? CW'(HOT_CYC - 1) : CW'(NORM_CYC - 1);
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= CW'(NORM_CYC - 1);
        else         cnt_q <= cnt_d;
    end

    // R3: hot flag seen at reload selects the short interval
    assert_hot_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && hot_i) |=> (cnt_q == CW'(HOT_CYC - 1)));

    // R2: normal reload length
    assert_norm_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && !hot_i) |=> (cnt_q == CW'(NORM_CYC - 1)));

    // R8: never two credits in a row
    assert_tick_spacing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int TW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [TW-1:0] len_i,
    output logic          busy_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start_i)            cnt_d = len_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R5: a started window is busy on the next cycle
    assert_busy_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && len_i != '0) |=> busy_o);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int CLK_PS      = 20000,
    parameter int TREFI_NS    = 7800,
    parameter int TRFC_NS     = 350,
    parameter int TRFC_PB_NS  = 90,
    parameter int NUM_BANKS   = 8,
    parameter int MAX_PEND    = 8,
    localparam int BW         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 hot_i,
    input  logic                 per_bank_i,
    input  logic                 rank_idle_i,
    output logic                 grant_o,
    output logic                 ref_cmd_o,
    output logic                 ref_all_o,
    output logic [BW-1:0]        ref_bank_o,
    output logic [NUM_BANKS-1:0] bank_busy_o
);
    localparam int REFI_CYC    = ns_to_cycles_floor(TREFI_NS, CLK_PS);
    localparam int REFI_HOT    = REFI_CYC / 2;
    localparam int TRFC_CYC    = ns_to_cycles_ceil(TRFC_NS, CLK_PS);
    localparam int TRFC_PB_CYC = ns_to_cycles_ceil(TRFC_PB_NS, CLK_PS);
    localparam int TMAX        = (TRFC_CYC > TRFC_PB_CYC) ? TRFC_CYC : TRFC_PB_CYC;
    localparam int TW          = $clog2(TMAX + 1);
    localparam int PW          = $clog2(MAX_PEND + 1);

    typedef struct packed {
        logic [PW-1:0] pend;
        logic [BW-1:0] ptr;
        logic          cmd;
        logic          all;
        logic [BW-1:0] bank;
    } sched_t;

    sched_t st_d, st_q;

    logic      tick;
    logic      issue;
    logic      target_busy;
    logic      rank_busy;
    ref_mode_e mode;
    logic [TW-1:0] bank_len;

    assign mode = per_bank_i ? MODE_BANK : MODE_RANK;

    refi_timer #(
        .NORM_CYC (REFI_CYC),
        .HOT_CYC  (REFI_HOT)
    ) u_refi (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hot_i  (hot_i),
        .tick_o (tick)
    );

    assign bank_len = (mode == MODE_BANK) ? TW'(TRFC_PB_CYC) : TW'(TRFC_CYC);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = issue && ((mode == MODE_RANK) || (st_q.ptr == BW'(b)));
        busy_timer #(.TW(TW)) u_busy (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .start_i (hit),
            .len_i   (bank_len),
            .busy_o  (bank_busy_o[b])
        );
    end

    busy_timer #(.TW(TW)) u_rank_busy (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (issue && (mode == MODE_RANK)),
        .len_i   (TW'(TRFC_CYC)),
        .busy_o  (rank_busy)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cmd = 1'b0;

        if (mode == MODE_BANK) target_busy = bank_busy_o[st_q.ptr];
        else                   target_busy = |bank_busy_o;

        issue = (st_q.pend != '0) && rank_idle_i && !target_busy;

        if (issue) begin
            st_d.cmd = 1'b1;
            if (mode == MODE_BANK) begin
                st_d.all  = 1'b0;
                st_d.bank = st_q.ptr;
                st_d.ptr  = (st_q.ptr == BW'(NUM_BANKS - 1)) ? '0 : st_q.ptr + 1'b1;
            end else begin
                st_d.all  = 1'b1;
                st_d.bank = '0;
            end
        end

        unique case ({tick, issue})
            2'b10: if (st_q.pend != PW'(MAX_PEND)) st_d.pend = st_q.pend + 1'b1;
            2'b01: st_d.pend = st_q.pend - 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ref_cmd_o  = st_q.cmd;
    assign ref_all_o  = st_q.all;
    assign ref_bank_o = st_q.bank;
    assign grant_o    = !rank_busy && (st_q.pend != PW'(MAX_PEND));

    // R7: backlog never exceeds its cap
    assert_pend_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pend <= PW'(MAX_PEND));

    // R4: commands only follow an idle rank
    assert_idle_before_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_cmd_o |-> $past(rank_idle_i));

    // R5: whole-rank command blocks every bank and the grant
    assert_rank_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_cmd_o && ref_all_o) |-> ((&bank_busy_o) && !grant_o && ref_bank_o == '0));

    // R6: whole-rank command never overlaps an earlier busy window
    assert_no_overlap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_cmd_o && ref_all_o) |-> ($past(bank_busy_o) == '0));

    // R9: per-bank command marks its own bank
    assert_bank_marked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_cmd_o && !ref_all_o) |-> bank_busy_o[ref_bank_o]);

    // R10: back-to-back per-bank commands move to the next bank
    assert_bank_rr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(ref_cmd_o && !ref_all_o) && ref_cmd_o && !ref_all_o) |->
        (ref_bank_o == (($past(ref_bank_o) == BW'(NUM_BANKS - 1)) ? '0 : $past(ref_bank_o) + 1'b1)));

endmodule

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;

    typedef struct {
        int cyc;
        bit all;
        int bank;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hot = 1'b0;
    logic       per_bank = 1'b0;
    logic       idle = 1'b1;
    logic       grant;
    logic       cmd;
    logic       all;
    logic [2:0] bank;
    logic [7:0] busy;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    refresh_sched dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .hot_i       (hot),
        .per_bank_i  (per_bank),
        .rank_idle_i (idle),
        .grant_o     (grant),
        .ref_cmd_o   (cmd),
        .ref_all_o   (all),
        .ref_bank_o  (bank),
        .bank_busy_o (busy)
    );

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
        end
    endtask

    task automatic push_exp(input int c, input bit a, input int b);
        exp_t e;
        e.cyc = c; e.all = a; e.bank = b;
        exp_q.push_back(e);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cmd) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected command", cyc, -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R2/R3/R8 command cycle", cyc, e.cyc);
                chk("R5/R9 all-bank flag", int'(all), int'(e.all));
                chk("R9/R10 bank index", int'(bank), e.bank);
            end
        end
    end

    task automatic do_reset(input bit h, input bit pb, input bit idl);
        @(negedge clk);
        rst_n = 1'b0; hot = h; per_bank = pb; idle = idl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic drained(input string tag);
        chk(tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired at cycle %0d", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        join_none

        // R1, R2, R5: idle rank, whole-rank mode
        do_reset(1'b0, 1'b0, 1'b1);
        chk("R1 cmd after reset", int'(cmd), 0);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 grant after reset", int'(grant), 1);
        push_exp(391, 1'b1, 0);
        push_exp(781, 1'b1, 0);
        push_exp(1171, 1'b1, 0);
        wait_cyc(390);
        chk("R1 nothing before first interval", int'(busy), 0);
        wait_cyc(392);
        chk("R5 all banks busy", int'(busy), 8'hFF);
        chk("R5 grant withdrawn", int'(grant), 0);
        wait_cyc(408);
        chk("R5 busy lasts 18 cycles", int'(busy), 8'hFF);
        wait_cyc(409);
        chk("R5 busy released", int'(busy), 0);
        chk("R5 grant restored", int'(grant), 1);
        wait_cyc(1200);
        drained("R2 all commands seen");

        // R3: temperature switch mid-interval, both directions
        do_reset(1'b0, 1'b0, 1'b1);
        push_exp(391, 1'b1, 0);
        push_exp(586, 1'b1, 0);
        push_exp(781, 1'b1, 0);
        push_exp(976, 1'b1, 0);
        push_exp(1366, 1'b1, 0);
        wait_cyc(100);
        hot = 1'b1;
        wait_cyc(800);
        hot = 1'b0;
        wait_cyc(1400);
        drained("R3 all commands seen");

        // R4, R6, R7, R8: busy rank, saturating backlog, drain
        do_reset(1'b0, 1'b0, 1'b0);
        wait_cyc(3119);
        chk("R7 grant high below cap", int'(grant), 1);
        wait_cyc(3120);
        chk("R7 grant low at cap", int'(grant), 0);
        wait_cyc(3590);
        chk("R4 no command while busy", int'(cmd), 0);
        chk("R7 grant still low", int'(grant), 0);
        for (int k = 0; k < 8; k++) push_exp(3601 + 19 * k, 1'b1, 0);
        push_exp(3901, 1'b1, 0);
        wait_cyc(3600);
        idle = 1'b1;
        wait_cyc(3752);
        chk("R6 grant back after drain", int'(grant), 1);
        wait_cyc(3950);
        drained("R7 exactly eight drained then R8 on time");

        // R9: per-bank mode, idle rank
        do_reset(1'b0, 1'b1, 1'b1);
        push_exp(391, 1'b0, 0);
        push_exp(781, 1'b0, 1);
        push_exp(1171, 1'b0, 2);
        wait_cyc(392);
        chk("R9 only bank 0 busy", int'(busy), 8'h01);
        chk("R9 grant kept", int'(grant), 1);
        wait_cyc(395);
        chk("R9 busy lasts 5 cycles", int'(busy), 8'h01);
        wait_cyc(396);
        chk("R9 bank busy released", int'(busy), 0);
        wait_cyc(1200);
        drained("R9 all commands seen");

        // R10: per-bank backlog, back-to-back banks, wrap
        do_reset(1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 8; k++) push_exp(3151 + k, 1'b0, k);
        push_exp(3511, 1'b0, 0);
        wait_cyc(3150);
        idle = 1'b1;
        wait_cyc(3152);
        chk("R10 grant with backlog below cap", int'(grant), 1);
        wait_cyc(3158);
        chk("R10 overlapping bank windows", int'(busy), 8'hF8);
        wait_cyc(3550);
        drained("R10 all commands seen");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule